// File: doc/BRIEF.md
# Power-of-Two Scaling Normaliser with Rounding

This block multiplies a signed 24-bit sample by a power of two picked by a 5-bit scale code, covering gains from 1/16384 up to 4. Reductions round to nearest, with ties going towards positive infinity. Increases saturate at the ends of the signed range. Codes above the valid range make the output zero. The block can therefore also act as a programmable mute.

The scale code comes from one of two sources. The first is a static code held steady by surrounding configuration logic. The second is a dynamic code that arrives with each sample, for example a field read from a per-sample table. A select input picks the source. A sample is accepted when its valid bit is high. The scaled result appears on a registered output one clock later, together with a registered valid. When no valid sample arrives, the output word keeps its last value.

Internally a code decoder sorts each code into one of four scaling classes: zero, right, unity and left. A rounding right shifter and a saturating left shifter run side by side, and the class picks which result is registered.

Top module: `pow2_normaliser`

## Requirements
- R1: After reset, out_valid is 0 and out_data is 0.
- R2: out_valid equals in_valid of the previous clock cycle. A sample accepted in one cycle is presented on out_data in the next cycle.
- R3: The effective code is dyn_code when use_dyn is 1, and static_code when use_dyn is 0. The code that is not selected has no effect on the result.
- R4: Effective code 14 gives unity gain: out_data equals the input sample.
- R5: Effective codes 0 to 13 scale by 2^(code-14). The hardware adds 2^(k-1) to the sample, with k = 14 - code, and then shifts arithmetically right by k. This is round-half-up.
- R6: Effective codes 15 and 16 shift left by 1 and by 2. A result above 0x7FFFFF becomes 0x7FFFFF, and a result below -0x800000 becomes 0x800000.
- R7: Effective codes 17 to 31 give out_data = 0.
- R8: In a cycle where in_valid is 0, out_data keeps its value, whatever is on the data and code inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 24 | Signed input sample |
| static_code | input | 5 | Scale code from static configuration |
| dyn_code | input | 5 | Per-sample scale code |
| use_dyn | input | 1 | 1 selects dyn_code, 0 selects static_code |
| out_valid | output | 1 | Registered valid |
| out_data | output | 24 | Registered scaled sample |

## Verification
Two behaviours can meet on a single sample: rounding that carries a value to the next step, and the source select. A worked example is an input of 8192 at code 0, which becomes exactly 1. With a left shift, the two behaviours that meet are saturation and the source select. The bench provokes these cases by giving the static and dynamic codes conflicting values on the same sample, for example 31 against 14, or 16 against 0. Each result is then compared with a bench model evaluated only on the selected code. Random samples with random codes and selects cover the other combinations, and idle cycles carrying different data confirm that the held output does not move.

// File: rtl/pow2_norm_pkg.sv
package pow2_norm_pkg;
    localparam int DATA_W     = 24;
    localparam int CODE_W     = 5;
    localparam int UNITY_CODE = 14;
    localparam int MAX_CODE   = 16;
    localparam int LSH_MAX    = MAX_CODE - UNITY_CODE;

    typedef enum logic [1:0] {
        SC_ZERO  = 2'd0,
        SC_RIGHT = 2'd1,
        SC_UNITY = 2'd2,
        SC_LEFT  = 2'd3
    } scale_cls_e;
endpackage

// File: rtl/pow2_code_decode.sv
module pow2_code_decode
    import pow2_norm_pkg::*;
#(
    parameter int CW    = CODE_W,
    parameter int UNITY = UNITY_CODE,
    parameter int TOP   = MAX_CODE
) (
    input  logic [CW-1:0] code,
    output scale_cls_e    cls,
    output logic [CW-1:0] rsh_amt,
    output logic [CW-1:0] lsh_amt
);
    localparam logic [CW-1:0] UNITY_C = CW'(UNITY);
    localparam logic [CW-1:0] TOP_C   = CW'(TOP);

    always_comb begin
        rsh_amt = '0;
        lsh_amt = '0;
        if (code > TOP_C) begin
            cls = SC_ZERO;
        end else if (code == UNITY_C) begin
            cls = SC_UNITY;
        end else if (code < UNITY_C) begin
            cls     = SC_RIGHT;
            rsh_amt = UNITY_C - code;
        end else begin
            cls     = SC_LEFT;
            lsh_amt = code - UNITY_C;
        end
    end
endmodule

// File: rtl/pow2_round_shift.sv
module pow2_round_shift #(
    parameter int W  = 24,
    parameter int AW = 5
) (
    input  logic signed [W-1:0] din,
    input  logic [AW-1:0]       amt,
    output logic signed [W-1:0] dout
);
    logic signed [W:0] ext;
    logic signed [W:0] half;
    logic signed [W:0] sum;
    logic signed [W:0] shifted;
    logic              unused_top;

    always_comb begin
        ext  = {din[W-1], din};
        half = '0;
        if (amt != '0)
            half = (W+1)'(1) << (amt - AW'(1));
        sum     = ext + half;
        shifted = sum >>> amt;
    end

    assign dout       = shifted[W-1:0];
    assign unused_top = shifted[W];
endmodule

// File: rtl/pow2_sat_shift.sv
module pow2_sat_shift #(
    parameter int W    = 24,
    parameter int AW   = 5,
    parameter int LMAX = 2
) (
    input  logic signed [W-1:0] din,
    input  logic [AW-1:0]       amt,
    output logic signed [W-1:0] dout
);
    localparam int EW = W + LMAX;
    localparam logic signed [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] NEG_MAX = {1'b1, {(W-1){1'b0}}};

    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] shifted;
    logic                 fits;

    always_comb begin
        ext     = {{LMAX{din[W-1]}}, din};
        shifted = ext <<< amt;
        fits    = (shifted[EW-1:W-1] == '0) || (shifted[EW-1:W-1] == '1);
        if (fits)
            dout = shifted[W-1:0];
        else if (shifted[EW-1])
            dout = NEG_MAX;
        else
            dout = POS_MAX;
    end
endmodule

// File: rtl/pow2_normaliser.sv
module pow2_normaliser
    import pow2_norm_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int CW    = CODE_W,
    parameter int UNITY = UNITY_CODE,
    parameter int TOP   = MAX_CODE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic [CW-1:0] static_code,
    input  logic [CW-1:0] dyn_code,
    input  logic          use_dyn,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    localparam int LMAX = TOP - UNITY;

    logic [CW-1:0] eff_code;
    scale_cls_e    cls;
    logic [CW-1:0] rsh_amt;
    logic [CW-1:0] lsh_amt;
    logic [DW-1:0] right_res;
    logic [DW-1:0] left_res;
    logic [DW-1:0] next_data;

    assign eff_code = use_dyn ? dyn_code : static_code;

    pow2_code_decode #(.CW(CW), .UNITY(UNITY), .TOP(TOP)) u_dec (
        .code    (eff_code),
        .cls     (cls),
        .rsh_amt (rsh_amt),
        .lsh_amt (lsh_amt)
    );

    pow2_round_shift #(.W(DW), .AW(CW)) u_rsh (
        .din  (in_data),
        .amt  (rsh_amt),
        .dout (right_res)
    );

    pow2_sat_shift #(.W(DW), .AW(CW), .LMAX(LMAX)) u_lsh (
        .din  (in_data),
        .amt  (lsh_amt),
        .dout (left_res)
    );

    always_comb begin
        unique case (cls)
            SC_ZERO:  next_data = '0;
            SC_RIGHT: next_data = right_res;
            SC_UNITY: next_data = in_data;
            SC_LEFT:  next_data = left_res;
            default:  next_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= next_data;
        end
    end
endmodule

module pow2_normaliser_chk #(
    parameter int DW = 24,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [DW-1:0] in_data,
    input logic [CW-1:0] static_code,
    input logic [CW-1:0] dyn_code,
    input logic          use_dyn,
    input logic          out_valid,
    input logic [DW-1:0] out_data
);
    logic [CW-1:0] sel_code;
    assign sel_code = use_dyn ? dyn_code : static_code;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    // R7
    zero_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_code > CW'(16)) |=> out_data == '0);
    // R4
    unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_code == CW'(14)) |=> out_data == $past(in_data));
    // R6
    left_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (sel_code == CW'(15) || sel_code == CW'(16)))
        |=> out_data[DW-1] == $past(in_data[DW-1]));
endmodule

bind pow2_normaliser pow2_normaliser_chk #(.DW(DW), .CW(CW)) u_chk (.*);

// File: tb/pow2_normaliser_tb.sv
module pow2_normaliser_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [23:0] in_data;
    logic [4:0]  static_code;
    logic [4:0]  dyn_code;
    logic        use_dyn;
    logic        out_valid;
    logic [23:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [23:0] last_exp = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pow2_normaliser u_dut (.*);

    function automatic logic [23:0] model(logic [23:0] x, logic [4:0] c);
        longint v;
        int k;
        v = longint'($signed(x));
        if (c > 5'd16) return 24'd0;
        if (c == 5'd14) return x;
        if (c < 5'd14) begin
            k = 14 - int'(c);
            v = (v + (longint'(1) <<< (k - 1))) >>> k;
        end else begin
            v = v <<< (int'(c) - 14);
            if (v > 64'sd8388607) v = 64'sd8388607;
            if (v < -64'sd8388608) v = -64'sd8388608;
        end
        return v[23:0];
    endfunction

    task automatic check(string req, logic [23:0] act, logic [23:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [23:0] x, logic [4:0] sc, logic [4:0] dc,
                         logic ud, string req);
        logic [23:0] e;
        e = model(x, ud ? dc : sc);
        @(negedge clk);
        in_valid = 1'b1; in_data = x; static_code = sc; dyn_code = dc; use_dyn = ud;
        @(posedge clk); #1;
        check(req, out_data, e);
        check("R2", {23'd0, out_valid}, 24'd1);
        last_exp = e;
    endtask

    task automatic idle(logic [23:0] x, logic [4:0] c);
        @(negedge clk);
        in_valid = 1'b0; in_data = x; static_code = c; dyn_code = c;
        @(posedge clk); #1;
        check("R8", out_data, last_exp);
        check("R2", {23'd0, out_valid}, 24'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5A17;
        void'($urandom(seed));
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
        static_code = '0; dyn_code = '0; use_dyn = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", out_data, 24'd0);
        check("R1", {23'd0, out_valid}, 24'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 unity
        apply(24'h123456, 5'd14, 5'd0, 1'b0, "R4");
        apply(24'h800000, 5'd14, 5'd0, 1'b0, "R4");
        // R5 rounding corners
        apply(24'd8192, 5'd0, 5'd0, 1'b0, "R5");          // exactly 1
        apply(24'd8191, 5'd0, 5'd0, 1'b0, "R5");          // rounds to 0
        apply(-24'sd8192, 5'd0, 5'd0, 1'b0, "R5");        // half up -> 0
        apply(-24'sd8193, 5'd0, 5'd0, 1'b0, "R5");        // -1
        apply(24'd3, 5'd13, 5'd0, 1'b0, "R5");            // 1.5 -> 2
        apply(24'h7FFFFF, 5'd13, 5'd0, 1'b0, "R5");
        apply(24'h800000, 5'd0, 5'd0, 1'b0, "R5");
        // R6 saturation
        apply(24'h7FFFFF, 5'd16, 5'd0, 1'b0, "R6");
        apply(24'h800000, 5'd15, 5'd0, 1'b0, "R6");
        apply(24'h1FFFFF, 5'd16, 5'd0, 1'b0, "R6");       // just fits
        apply(24'hE00000, 5'd16, 5'd0, 1'b0, "R6");       // exactly min
        apply(24'h200000, 5'd16, 5'd0, 1'b0, "R6");       // just over
        // R7 out of range
        apply(24'h7FFFFF, 5'd17, 5'd0, 1'b0, "R7");
        apply(24'h800001, 5'd31, 5'd0, 1'b0, "R7");
        // R3 conflicting sources
        apply(24'h0ABCDE, 5'd31, 5'd14, 1'b1, "R3");
        apply(24'h0ABCDE, 5'd14, 5'd31, 1'b0, "R3");
        apply(24'h7FFFFF, 5'd0, 5'd16, 1'b1, "R3");
        apply(24'd8192, 5'd16, 5'd0, 1'b1, "R3");
        // R8 idle hold with disturbing inputs
        idle(24'h555555, 5'd14);
        idle(24'h000000, 5'd31);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [23:0] x;
            logic [4:0] sc, dc;
            x  = 24'($urandom);
            sc = 5'($urandom_range(0, 20));
            dc = 5'($urandom_range(0, 20));
            if (($urandom & 32'h7) == 0) x = (($urandom & 1) != 0) ? 24'h7FFFFF : 24'h800000;
            apply(x, sc, dc, 1'($urandom), "R5/R6 random");
            if (($urandom & 32'hF) == 0) idle(24'($urandom), 5'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule